// File: doc/BRIEF.md
# Symmetric Multiplierless Q15 Low-Pass FIR

This block is a seven-tap, linear-phase, low-pass FIR filter for signed 16-bit samples in Q1.15 format. When the input strobe is high, the block takes one sample into its delay line. Every accepted sample produces exactly one filtered sample at the output, marked by the output strobe. The filter computes y(n) = sum of b_i·x(n−i) for i = 0..6, so the filter length is K+1 = 7 with K = 6.

The coefficients are fixed and mirror-symmetric (b_i = b_(6−i)). The two samples that share a coefficient are added first, and only four weighted terms are formed: three pairs and the unpaired centre tap. Each weight is built from shifted copies of its operand. One times-three term is shared by two coefficients, and another is reused inside a third. The block contains no general multiplier. The wide sum is rounded half-up at bit 15 and then clamped into the Q15 range.

Top module: `sym_fir_q15`

## Requirements
- R1: During synchronous active-low reset and in the first cycle after it, `out_valid` is 0 and `out_sample` is 0. Reset clears all seven delay-line entries, so the first outputs after reset see zeros as their earlier samples.
- R2: The integer coefficients, in units of 2^-15, are b0..b6 = −1024, 3072, 9219, 12288, 9219, 3072, −1024. Before rounding, the output for the newest accepted sample x(n) is A = sum of b_i·x(n−i), where x(n−i) is the i-th earlier accepted sample.
- R3: `out_valid` is high for exactly one cycle for each accepted input. It appears after the third rising edge, counting the edge that samples `in_valid` high as the first. This holds for consecutive inputs. `out_valid` is never high without a matching input.
- R4: While `in_valid` is low, `in_sample` is ignored: the delay line does not move, and later outputs depend only on accepted samples.
- R5: Rounding is half-up: the result is floor((A + 2^14) / 2^15). For example, a lone value 4 at the centre tap gives A = 49152 and output 2, and −4 gives output −1.
- R6: A rounded result above 32767 is output as 0x7FFF, and one below −32768 is output as 0x8000.
- R7: An impulse of −32768 followed by zeros produces the outputs −b0, −b1, …, −b6 exactly, so the response is symmetric in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | 16 | Signed Q1.15 input sample |
| out_valid | output | 1 | High for one cycle with each filtered sample |
| out_sample | output | 16 | Signed Q1.15 output: rounded and saturated |

## Verification
Two things can happen in the same cycle: a new sample shifts into the delay line while earlier results are still moving through the sum and rounding registers. The bench sends back-to-back bursts mixed with random idle gaps. Every output is compared, in order and at its expected cycle, against a model that keeps its own sample history. Full-scale steady inputs push the rounding and the clamp into the same result, which checks that saturation is applied after the half-up increment.

// File: rtl/sym_fir_pkg.sv
// Package: sym_fir_pkg
// Shared widths and latency for the symmetric Q15 FIR. These are the
// defaults for the module parameters.
package sym_fir_pkg;
    localparam int DATA_W  = 16;  // sample width, Q1.15
    localparam int FRAC_W  = 15;  // fractional bits of samples and coefficients
    localparam int ACC_W   = 36;  // sum width with guard bits
    localparam int TAPS    = 7;   // filter length, odd
    localparam int LATENCY = 3;   // edges from input strobe to output strobe
endpackage

// File: rtl/sym_fir_tap_line.sv
// Module: sym_fir_tap_line
// Holds the last TAPS accepted samples; entry 0 is the newest. Forms the
// mirrored pre-sums tap[i] + tap[TAPS-1-i] one bit wider than a sample,
// and passes the unpaired centre tap out alone.
// Assumes TAPS is odd. Synchronous active-low reset clears every entry.
module sym_fir_tap_line #(
    parameter int DATA_W = 16,
    parameter int TAPS   = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic signed [DATA_W-1:0]    din,
    output logic signed [DATA_W:0]      pre_sum [TAPS/2],
    output logic signed [DATA_W-1:0]    centre
);
    localparam int HALF  = TAPS / 2;
    localparam int PRE_W = DATA_W + 1;

    logic signed [DATA_W-1:0] tap [TAPS];

    // Shift the newest sample in on each accepted input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) tap[i] <= '0;
        end else if (shift_en) begin
            tap[0] <= din;
            for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
        end
    end

    // One pre-adder for each mirrored pair of taps
    for (genvar g = 0; g < HALF; g++) begin : g_pre
        assign pre_sum[g] = PRE_W'({tap[g][DATA_W-1], tap[g]})
                          + PRE_W'({tap[TAPS-1-g][DATA_W-1], tap[TAPS-1-g]});
    end

    assign centre = tap[HALF];

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(tap[0]) && $stable(tap[TAPS-1])));

    // R2
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (tap[1] == $past(tap[0])));
endmodule

// File: rtl/sym_fir_shiftadd_mac.sv
// Module: sym_fir_shiftadd_mac
// Weights three pre-sums and the centre tap by fixed coefficients, using
// only shifts and adds, and registers the sum.
// Coefficients (units of 2^-15): pair0 -1024, pair1 3072, pair2 9219,
// centre 12288. Factored form:
//   A = ((3*(p1 + 4*c) + 9*p2 - p0) << 10) + 3*p2
// The times-three network is shared between pair1 and the centre, and
// 3*p2 is reused in 9*p2 and in the low term.
// Assumes exactly three pairs (seven taps) and ACC_W well above DATA_W+16.
module sym_fir_shiftadd_mac #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 36
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic signed [DATA_W:0]      pre_sum [3],
    input  logic signed [DATA_W-1:0]    centre,
    output logic signed [ACC_W-1:0]     acc_q
);
    localparam int PRE_W = DATA_W + 1;

    logic signed [ACC_W-1:0] p0, p1, p2, c;
    logic signed [ACC_W-1:0] u, x3u, x3p2, x9p2, hi_sum, acc_d;

    // Sign-extend the operands and form the shared shift-add terms
    always_comb begin
        p0     = {{(ACC_W-PRE_W){pre_sum[0][PRE_W-1]}}, pre_sum[0]};
        p1     = {{(ACC_W-PRE_W){pre_sum[1][PRE_W-1]}}, pre_sum[1]};
        p2     = {{(ACC_W-PRE_W){pre_sum[2][PRE_W-1]}}, pre_sum[2]};
        c      = {{(ACC_W-DATA_W){centre[DATA_W-1]}}, centre};
        u      = p1 + (c <<< 2);
        x3u    = (u <<< 1) + u;
        x3p2   = (p2 <<< 1) + p2;
        x9p2   = (x3p2 <<< 1) + x3p2;
        hi_sum = x3u + x9p2 - p0;
        acc_d  = (hi_sum <<< 10) + x3p2;
    end

    // Capture the weighted sum one cycle after the delay line moves
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_d;
    end
endmodule

// File: rtl/sym_fir_round_sat.sv
// Module: sym_fir_round_sat
// Rounds the wide sum half-up at bit FRAC_W, clamps it to the signed
// DATA_W range and registers the result with its strobe.
// Assumes ACC_W > DATA_W + FRAC_W. Reset clears the output and the strobe.
module sym_fir_round_sat #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 15,
    parameter int ACC_W  = 36
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic signed [ACC_W-1:0]     acc,
    output logic                        out_valid,
    output logic signed [DATA_W-1:0]    out_sample
);
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC_W-1);
    localparam logic signed [ACC_W-1:0] SAT_HI   = (ACC_W'(1) <<< (DATA_W-1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_LO   = -(ACC_W'(1) <<< (DATA_W-1));

    logic signed [ACC_W-1:0]  rounded;
    logic signed [DATA_W-1:0] clamped;

    // Add half an output LSB, drop fraction bits, then clamp
    always_comb begin
        rounded = (acc + HALF_LSB) >>> FRAC_W;
        if (rounded > SAT_HI)      clamped = SAT_HI[DATA_W-1:0];
        else if (rounded < SAT_LO) clamped = SAT_LO[DATA_W-1:0];
        else                       clamped = rounded[DATA_W-1:0];
    end

    // Register the result and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= en;
            if (en) out_sample <= clamped;
        end
    end

    // R6
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (acc > (SAT_HI <<< FRAC_W))) |=> (out_sample == SAT_HI[DATA_W-1:0]));

    // R6
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (acc < (SAT_LO <<< FRAC_W) - HALF_LSB)) |=> (out_sample == SAT_LO[DATA_W-1:0]));
endmodule

// File: rtl/sym_fir_q15.sv
// Module: sym_fir_q15
// Top of the symmetric multiplierless Q15 FIR. Three register stages:
// the delay line, the weighted sum, and the rounded/saturated output.
// out_valid follows an accepted input after LATENCY rising edges.
// Assumes the seven-tap coefficient set fixed in sym_fir_shiftadd_mac.
module sym_fir_q15 #(
    parameter int DATA_W = sym_fir_pkg::DATA_W,
    parameter int FRAC_W = sym_fir_pkg::FRAC_W,
    parameter int ACC_W  = sym_fir_pkg::ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);
    localparam int TAPS = sym_fir_pkg::TAPS;

    logic signed [DATA_W:0]   pre_sum [TAPS/2];
    logic signed [DATA_W-1:0] centre;
    logic signed [ACC_W-1:0]  acc_q;
    logic [1:0]               vpipe;

    // Carry the strobe alongside the delay-line and sum stages
    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[0], in_valid};
    end

    sym_fir_tap_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_taps (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_sample),
        .pre_sum(pre_sum), .centre(centre));

    sym_fir_shiftadd_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .en(vpipe[0]),
        .pre_sum(pre_sum), .centre(centre), .acc_q(acc_q));

    sym_fir_round_sat #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_out (
        .clk(clk), .rst_n(rst_n), .en(vpipe[1]), .acc(acc_q),
        .out_valid(out_valid), .out_sample(out_sample));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 3));
endmodule

// File: tb/sym_fir_q15_bench.sv
module sym_fir_q15_bench;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [15:0] out_sample;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    string cur_req = "R2";

    longint hist [7];
    int     exp_q [$];
    int     due_q [$];
    string  req_q [$];

    sym_fir_q15 u_sym_fir_q15 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint coef(int i);
        case (i)
            0, 6: return -1024;
            1, 5: return 3072;
            2, 4: return 9219;
            default: return 12288;
        endcase
    endfunction

    function automatic int round_sat(longint a);
        longint r;
        r = (a + 64'sd16384) >>> 15;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Accept one sample: update model history and queue the expected output
    task automatic send(int x);
        longint a;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        for (int i = 6; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        a = 0;
        for (int i = 0; i < 7; i++) a += coef(i) * hist[i];
        exp_q.push_back(round_sat(a));
        due_q.push_back(cyc + 3);
        req_q.push_back(cur_req);
    endtask

    // Leave a cycle idle with junk on the sample bus
    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 16'($urandom);
        end
    endtask

    task automatic drain();
        idle(6);
    endtask

    // Compare each output at the cycle it is due
    always @(negedge clk) begin
        if (rst_n) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                checks++;
                if (!out_valid) begin
                    fails++;
                    $display("FAIL R3 out_valid=0 expected 1 at cycle %0d", cyc);
                end else if (int'(out_sample) != exp_q[0]) begin
                    fails++;
                    $display("FAIL %s out_sample=%0d expected %0d", req_q[0],
                             out_sample, exp_q[0]);
                end
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
                void'(req_q.pop_front());
            end else if (out_valid) begin
                checks++;
                fails++;
                $display("FAIL R3 out_valid=1 expected 0 at cycle %0d", cyc);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 7; i++) hist[i] = 0;
        repeat (4) @(negedge clk);
        // R1: reset state, checked during reset and after release
        checks++;
        if (out_valid !== 1'b0 || out_sample !== 16'sd0) begin
            fails++;
            $display("FAIL R1 valid=%b out=%0d expected 0/0", out_valid, out_sample);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sample !== 16'sd0) begin
            fails++;
            $display("FAIL R1 valid=%b out=%0d expected 0/0", out_valid, out_sample);
        end

        // R7 and R1: impulse of -1.0 straight after reset gives -b_i
        cur_req = "R7";
        send(-32768);
        for (int i = 0; i < 6; i++) send(0);
        drain();

        // R5: half-LSB ties at the centre tap round up
        cur_req = "R5";
        send(4); send(0); send(0); send(0);
        for (int i = 0; i < 3; i++) send(0);
        send(-4); send(0); send(0); send(0);
        for (int i = 0; i < 3; i++) send(0);
        drain();

        // R6: steady full scale saturates both ways
        cur_req = "R6";
        for (int i = 0; i < 9; i++) send(32767);
        for (int i = 0; i < 9; i++) send(-32768);
        drain();

        // R4: junk while idle is ignored between accepted samples
        cur_req = "R4";
        send(1200); idle(3); send(-700); idle(5); send(3000); idle(1); send(5);
        drain();

        // R2 and R3: random streaming with random gaps
        cur_req = "R2";
        for (int k = 0; k < 600; k++) begin
            if (($urandom % 10) < 3) idle(1 + ($urandom % 3));
            if (k < 300) send(int'($signed(16'($urandom))));
            else         send(int'($signed(16'($urandom))) >>> 6);
        end
        drain();

        // R3: long back-to-back burst
        cur_req = "R3";
        for (int k = 0; k < 40; k++) send(int'($signed(16'($urandom))));
        drain();

        finish_run();
    end
endmodule